// File: doc/BRIEF.md
# Change-of-State Edge Capture Interrupt Controller

This block monitors thirty-two digital input lines and latches every qualifying transition into a sticky status bit. The lines are twenty-four isolated inputs and eight TTL-level lines. They form four groups of eight: isolated bits 0-7, 8-15 and 16-23, then the TTL byte. Each group has two enable bits, one for rising transitions and one for falling transitions. Setting both enables makes a group capture edges in either direction.

Software uses a byte-wide register port. Through it, software reads the synchronized line levels, reads the captured status and reads or writes the edge enables. It acknowledges events by writing ones to the status bytes. An interrupt line stays high while any status bit is set. The intended handling is to read a status byte and write the same value back, which clears exactly the events that were read.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the enable byte reads 0x00, every status bit is 0 and `irq` is low.
- R2: Offset 0xE holds the 8-bit edge enable byte. A write there is stored, and a read there returns the stored value.
- R3: Enable bit g (g = 0..3) arms rising-edge capture for group g. Group 0 is iso_in[7:0], group 1 is iso_in[15:8], group 2 is iso_in[23:16] and group 3 is ttl_in[7:0]. A synchronized 0-to-1 transition on an armed line sets that line's status bit. The bit is set by the third rising clock edge after the input changes.
- R4: Enable bit 4+g arms falling-edge capture for group g, with the same group numbering and timing as R3.
- R5: A transition whose direction is not armed for its group leaves the status unchanged.
- R6: A read at offset 0x8, 0x9 or 0xA returns the status of iso_in[7:0], [15:8] or [23:16] respectively. A read at offset 0xB returns the status of ttl_in. Bit i of each byte belongs to line i of that byte.
- R7: A write to a status offset (0x8-0xB) clears exactly the status bits written as 1. Every other status bit keeps its value.
- R8: When a capture and a clear of the same bit occur in the same cycle, the bit ends up set.
- R9: A read at offset 0x4, 0x5 or 0x6 returns the synchronized level of the matching isolated byte. A read at offset 0x7 returns the synchronized TTL level.
- R10: `irq` is high exactly while at least one status bit is set. It stays high until the last set bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_in | input | 24 | Isolated input lines, asynchronous |
| ttl_in | input | 8 | TTL input lines, asynchronous |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench targets the points where an edge detector usually goes wrong. It drives mixed-direction changes within one group, and a wrong-direction change in a group armed for only one direction; mixing up the rising and falling enables, or their group order, sets the wrong bits. A partial acknowledge must leave the other bits and the interrupt intact, so a design that clears the whole byte, or drops `irq` early, is caught. A capture timed to land in the same cycle as its own clear must survive; a design that gives the clear priority loses that event.

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int ISO_W    = 24,
  parameter int TTL_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int LVL_BASE = 4,
  parameter int STS_BASE = 8,
  parameter int CFG_ADDR = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ISO_W-1:0]    iso_in,
  input  logic [TTL_W-1:0]    ttl_in,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  output logic                irq
);
  localparam int GRP_W    = 8;
  localparam int N_IN     = ISO_W + TTL_W;
  localparam int N_GROUPS = N_IN / GRP_W;
  localparam int CFG_W    = 2 * N_GROUPS;

  logic [N_IN-1:0]  meta_q, sync_q, prev_q;
  logic [N_IN-1:0]  status_q, set_vec, clr_vec;
  logic [CFG_W-1:0] en_q;

  wire [N_IN-1:0] raw   = {ttl_in, iso_in};
  wire [N_IN-1:0] rises = sync_q & ~prev_q;
  wire [N_IN-1:0] falls = ~sync_q & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign set_vec[g*GRP_W +: GRP_W] =
        (rises[g*GRP_W +: GRP_W] & {GRP_W{en_q[g]}}) |
        (falls[g*GRP_W +: GRP_W] & {GRP_W{en_q[N_GROUPS+g]}});
    assign clr_vec[g*GRP_W +: GRP_W] =
        (wr_en && addr == ADDR_W'(STS_BASE + g)) ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      status_q <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(CFG_ADDR)) en_q <= CFG_W'(wr_data);
      status_q <= (status_q & ~clr_vec) | set_vec;
    end
  end

  assign irq = |status_q;

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CFG_ADDR)) rd_data = 8'(en_q);
    for (int b = 0; b < N_GROUPS; b++) begin
      if (addr == ADDR_W'(LVL_BASE + b)) rd_data = sync_q[b*GRP_W +: GRP_W];
      if (addr == ADDR_W'(STS_BASE + b)) rd_data = status_q[b*GRP_W +: GRP_W];
    end
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R2

  AST_NEW_BIT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~($past(sync_q) ^ $past(prev_q))) == '0)); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0)); // R7

  AST_IRQ_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en)); // R10
endmodule

// File: tb/cos_irq_ctrl_tb_top.sv
module cos_irq_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] iso_in = '0;
  logic [7:0]  ttl_in = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .iso_in(iso_in), .ttl_in(ttl_in),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  localparam int NV = 10;
  localparam logic [7:0]  V_EN  [NV] = '{8'h01, 8'h02, 8'h08, 8'h10, 8'h80,
                                         8'h00, 8'hFF, 8'h04, 8'h44, 8'h22};
  localparam logic [31:0] V_PRE [NV] = '{32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                         32'h0, 32'h00FF00FF, 32'h00FF0000, 32'h00F00000, 32'h0000AA00};
  localparam logic [31:0] V_NEW [NV] = '{32'h000000FF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000000F, 32'h0,
                                         32'hFFFFFFFF, 32'hFF00FF00, 32'h0, 32'h000F0000, 32'h00005500};
  localparam logic [31:0] V_EXP [NV] = '{32'h000000FF, 32'h0000FF00, 32'hFF000000, 32'h000000F0, 32'hFF000000,
                                         32'h0, 32'hFFFFFFFF, 32'h0, 32'h00FF0000, 32'h0000FF00};
  string v_tag [NV] = '{"R3", "R3", "R3", "R4", "R4", "R5", "R4", "R5", "R4", "R4"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd32(logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(base + 4'(k), b);
      v[k*8 +: 8] = b;
    end
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk);
    {ttl_in, iso_in} = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(4'(8 + k), 8'hFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'hE, b);    check("R1 enable", 32'(b), 0);
    rd32(4'h8, w);  check("R1 status", w, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 enable readback
    wr(4'hE, 8'hA5);
    rd(4'hE, b);    check("R2 enable readback", 32'(b), 32'hA5);

    for (int i = 0; i < NV; i++) begin
      wr(4'hE, 8'h00);
      drive(V_PRE[i]);
      settle();
      clear_all();
      wr(4'hE, V_EN[i]);
      drive(V_NEW[i]);
      settle();
      rd32(4'h8, w);  check($sformatf("%s R6 vector %0d status", v_tag[i], i), w, V_EXP[i]);
      check($sformatf("R10 vector %0d irq", i), 32'(irq), 32'(V_EXP[i] != 0));
      rd32(4'h4, w);  check($sformatf("R9 vector %0d levels", i), w, V_NEW[i]);
    end

    // R7 / R10 partial acknowledge
    wr(4'hE, 8'h00);
    drive(32'h0);
    settle();
    clear_all();
    wr(4'hE, 8'h01);
    drive(32'h000000FF);
    settle();
    wr(4'h8, 8'h0F);
    rd(4'h8, b);    check("R7 partial clear", 32'(b), 32'hF0);
    check("R10 irq held after partial clear", 32'(irq), 1);
    wr(4'h8, 8'hF0);
    rd(4'h8, b);    check("R7 remaining clear", 32'(b), 0);
    check("R10 irq low after full clear", 32'(irq), 0);

    // R8 capture coincides with clear
    wr(4'hE, 8'h11);
    drive(32'h000000FE);
    settle();
    rd(4'h8, b);    check("R4 falling bit0 set", 32'(b), 32'h01);
    @(negedge clk);
    iso_in = 24'h0000FF;
    @(negedge clk);
    @(negedge clk);
    addr = 4'h8; wr_data = 8'h01; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = '0;
    rd(4'h8, b);    check("R8 set wins over clear", 32'(b), 32'h01);
    check("R10 irq with surviving bit", 32'(irq), 1);
    wr(4'h8, 8'h01);
    rd(4'h8, b);    check("R7 later clear", 32'(b), 0);

    finish_run();
  end
endmodule